// File: doc/BRIEF.md
# Lockable Security Control Register

This block holds a 32-bit security control word behind a small word-wide register bus. A second register holds five sticky lock bits. Each lock bit freezes one group of control fields at its present value until reset. A third register takes an unlock key. Writing the correct key sets the reconfiguration-port enable and the three encryption-enable bits and keeps the block reachable. Writing any other value clears those fields and closes the block to the bus. While the block is closed, only the key register still accepts writes.

Requests use a valid/ready handshake. `req_ready` is tied high, so the block never applies back-pressure and takes a request in every cycle where `req_valid` is high. A read returns its data through `rsp_valid`/`rsp_rdata` exactly one cycle later, and every read request gets a response. The response has no ready input, so the requester must accept each one. The control word drives the rest of the chip directly through `ctrl_q`. The block also reports whether the bus is open (`access_en`) and whether the encryption-enable field holds a mixed value (`aes_mixed`).

Register byte offsets: control at 0x0, lock at 0x4, key at 0x8.

Top module: `seclk_top`

## Requirements
- R1: After reset, control reads 0x0C006000, lock reads 0, `access_en` is 1 and `aes_mixed` is 0.
- R2: Only lock bits 4:0 exist, and upper bits read zero. A lock write ORs its data into the current value, so a lock bit can be cleared only by reset.
- R3: On a control write, a field guarded by a set lock bit keeps its old value. Lock bit 0 guards control bits 6:0. Lock bit 1 guards bit 7. Lock bit 2 guards bit 8. Lock bit 3 guards bits 11:9. Lock bit 4 guards bit 12. Every other writable field takes the written data.
- R4: Control bits 30:29, 27:23 and 12:0 are writable. Bits 14:13 always read one. Bits 31, 28 and 22:15 read zero and ignore writes.
- R5: Writing 0x757BDF0D to the key register sets control bit 27 and bits 11:9, regardless of locks, and leaves `access_en` high. The key register reads zero.
- R6: Writing any other value to the key register clears control bit 27 and bits 11:9, and drops `access_en`.
- R7: While `access_en` is low, reads return zero and writes to control and lock are dropped. A key write is still accepted.
- R8: A request is honoured only when `req_size` is 2 (a word) and `req_addr[1:0]` is 0. Any other request changes no state, and a read of that kind returns zero.
- R9: `aes_mixed` is high exactly when control bits 11:9 are neither 000 nor 111.
- R10: `req_ready` is always high. A read accepted in one cycle produces `rsp_valid` high with its data in the next cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| ctrl_q | output | 32 | Current control word |
| access_en | output | 1 | Register block open to bus |
| aes_mixed | output | 1 | Encryption-enable field inconsistent |

## Verification
The bench sweeps all 32 lock values from two starting points: all writable bits set, then the reset value. It writes the complement each time, which shows both directions of freezing for every group. It drives all eight encryption-enable codes to separate the two consistent values from the six mixed ones. It drives wrong sizes and misaligned addresses, and a wrong key followed by the right key. These separate the dropped requests from the honoured ones and show that the key register still works while the block is closed.

// File: rtl/seclk_pkg.sv
package seclk_pkg;
  localparam int unsigned NLOCK = 5;
  localparam logic [31:0] CTRL_RST    = 32'h0C00_6000;
  localparam logic [31:0] CTRL_WMASK  = 32'h6F80_1FFF;
  localparam logic [31:0] CTRL_RO1    = 32'h0000_6000;
  localparam logic [31:0] UNLK_FIELDS = 32'h0800_0E00;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_RSVD = 2'd3} acc_size_e;

  // control bits guarded by each lock bit
  function automatic logic [31:0] lock_group(input int unsigned idx);
    case (idx)
      0: lock_group = 32'h0000_007F;
      1: lock_group = 32'h0000_0080;
      2: lock_group = 32'h0000_0100;
      3: lock_group = 32'h0000_0E00;
      4: lock_group = 32'h0000_1000;
      default: lock_group = 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/seclk_lock_reg.sv
module seclk_lock_reg
  import seclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NLOCK-1:0] wdata,
  output logic [NLOCK-1:0] lock_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     lock_q <= '0;
    else if (wr_en) lock_q <= lock_q | wdata;
  end

  // R2: lock bits never fall
  a_r2_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));
endmodule

// File: rtl/seclk_unlock.sv
module seclk_unlock #(
  parameter logic [31:0] KEY = 32'h757B_DF0D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic        unlock_ok,
  output logic        unlock_bad,
  output logic        access_en
);
  logic key_match;
  assign key_match  = (wdata == KEY);
  assign unlock_ok  = wr_en && key_match;
  assign unlock_bad = wr_en && !key_match;

  always_ff @(posedge clk) begin
    if (!rst_n)          access_en <= 1'b1;
    else if (unlock_ok)  access_en <= 1'b1;
    else if (unlock_bad) access_en <= 1'b0;
  end

  // R5: correct key opens block
  a_r5_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata == KEY) |=> access_en);
  // R6: wrong key closes block
  a_r6_bad_key_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata != KEY) |=> !access_en);
endmodule

// File: rtl/seclk_ctrl_reg.sv
module seclk_ctrl_reg
  import seclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wdata,
  input  logic [NLOCK-1:0] lock_q,
  input  logic             unlock_ok,
  input  logic             unlock_bad,
  output logic [31:0]      ctrl_q
);
  logic [NLOCK-1:0][31:0] grp;
  logic [31:0] keep, nxt;

  for (genvar g = 0; g < NLOCK; g++) begin : g_grp
    assign grp[g] = lock_q[g] ? lock_group(g) : 32'h0;

    // R3: a guarded field holds while its lock is set, apart from key effects
    a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q[g] && !unlock_ok && !unlock_bad)
        |=> (((ctrl_q ^ $past(ctrl_q)) & lock_group(g) & ~UNLK_FIELDS) == 32'h0));
  end

  always_comb begin
    keep = 32'h0;
    for (int i = 0; i < NLOCK; i++) keep = keep | grp[i];
  end

  always_comb begin
    nxt = ctrl_q;
    if (wr_en)      nxt = (ctrl_q & keep) | (wdata & CTRL_WMASK & ~keep) | CTRL_RO1;
    if (unlock_ok)  nxt = nxt | UNLK_FIELDS;
    if (unlock_bad) nxt = nxt & ~UNLK_FIELDS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= CTRL_RST;
    else        ctrl_q <= nxt;
  end
endmodule

// File: rtl/seclk_top.sv
module seclk_top
  import seclk_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter logic [31:0] KEY    = 32'h757B_DF0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [31:0]       ctrl_q,
  output logic              access_en,
  output logic              aes_mixed
);
  localparam int unsigned SEL_W = ADDR_W - 2;
  localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_LOCK = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_KEY  = SEL_W'(2);

  logic             acc_ok, wr_ctrl, wr_lock, wr_key;
  logic             unlock_ok, unlock_bad;
  logic [SEL_W-1:0] sel;
  logic [NLOCK-1:0] lock_q;
  logic [31:0]      rd_mux;

  assign req_ready = 1'b1;
  assign acc_ok  = req_valid && (req_size == SZ_WORD) && (req_addr[1:0] == 2'b00);
  assign sel     = req_addr[ADDR_W-1:2];
  assign wr_ctrl = acc_ok && req_write && access_en && (sel == SEL_CTRL);
  assign wr_lock = acc_ok && req_write && access_en && (sel == SEL_LOCK);
  assign wr_key  = acc_ok && req_write && (sel == SEL_KEY);

  seclk_lock_reg u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_lock),
    .wdata(req_wdata[NLOCK-1:0]), .lock_q(lock_q)
  );

  seclk_unlock #(.KEY(KEY)) u_unlock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_key), .wdata(req_wdata),
    .unlock_ok(unlock_ok), .unlock_bad(unlock_bad), .access_en(access_en)
  );

  seclk_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wdata(req_wdata),
    .lock_q(lock_q), .unlock_ok(unlock_ok), .unlock_bad(unlock_bad),
    .ctrl_q(ctrl_q)
  );

  always_comb begin
    case (sel)
      SEL_CTRL: rd_mux = ctrl_q;
      SEL_LOCK: rd_mux = {{(32-NLOCK){1'b0}}, lock_q};
      default:  rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 32'h0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (acc_ok && !req_write && access_en) ? rd_mux : 32'h0;
    end
  end

  assign aes_mixed = (ctrl_q[11:9] != 3'b000) && (ctrl_q[11:9] != 3'b111);

  // R7: closed block answers reads with zero
  a_r7_closed_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !access_en) |=> (rsp_rdata == 32'h0));
  // R7: closed block drops control writes
  a_r7_closed_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !access_en && sel != SEL_KEY) |=> $stable(ctrl_q));
  // R8: wrong-size writes change nothing
  a_r8_size_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_size != SZ_WORD) |=> ($stable(ctrl_q) && $stable(access_en)));
  // R10: response follows a read by one cycle
  a_r10_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  // R5: key sets the reconfiguration and encryption fields
  a_r5_key_sets_fields: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_ok |=> (ctrl_q[27] && ctrl_q[11:9] == 3'b111));
endmodule

// File: tb/seclk_top_tb.sv
module seclk_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, access_en, aes_mixed;
  logic [31:0] rsp_rdata, ctrl_q;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [31:0] WM  = 32'h6F80_1FFF;
  localparam logic [31:0] RO  = 32'h0000_6000;
  localparam logic [31:0] RST = 32'h0C00_6000;
  localparam logic [31:0] KEYV = 32'h757B_DF0D;

  always #10 clk = ~clk;

  seclk_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ctrl_q(ctrl_q), .access_en(access_en), .aes_mixed(aes_mixed)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_size = 2'd2;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0; req_size = 2'd2;
    chk("R10 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    d = rsp_rdata;
  endtask

  function automatic logic [31:0] lmask(input logic [4:0] l);
    logic [31:0] m = 0;
    if (l[0]) m |= 32'h7F;
    if (l[1]) m |= 32'h80;
    if (l[2]) m |= 32'h100;
    if (l[3]) m |= 32'hE00;
    if (l[4]) m |= 32'h1000;
    return m;
  endfunction

  initial begin
    logic [31:0] v, base, m;
    do_reset();
    // R1 reset state
    rd(4'h0, v); chk("R1 ctrl reset", v, RST);
    rd(4'h4, v); chk("R1 lock reset", v, 0);
    chk("R1 access_en", {31'b0, access_en}, 1);
    chk("R1 aes_mixed", {31'b0, aes_mixed}, 0);
    chk("R10 req_ready", {31'b0, req_ready}, 1);
    @(negedge clk); chk("R10 no rsp idle", {31'b0, rsp_valid}, 0);
    // R4 writable mask
    wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, v); chk("R4 all ones", v, WM | RO);
    wr(4'h0, 32'h0); rd(4'h0, v); chk("R4 all zeros", v, RO);
    // R2 / R3 sweep over every lock value
    for (int l = 0; l < 32; l++) begin
      m = lmask(l[4:0]);
      do_reset();
      wr(4'h0, 32'hFFFF_FFFF);
      wr(4'h4, 32'hFFFF_FFE0 | l);
      rd(4'h4, v); chk("R2 lock value", v, l);
      wr(4'h4, 32'h0);
      rd(4'h4, v); chk("R2 lock sticky", v, l);
      base = WM | RO;
      wr(4'h0, 32'h0);
      rd(4'h0, v); chk("R3 freeze ones", v, (base & m) | RO);
      do_reset();
      wr(4'h4, l);
      wr(4'h0, 32'hFFFF_FFFF);
      rd(4'h0, v); chk("R3 freeze reset", v, (RST & m) | (WM & ~m) | RO);
    end
    // R9 every encryption-enable code
    for (int f = 0; f < 8; f++) begin
      do_reset();
      wr(4'h0, f << 9);
      chk("R9 aes_mixed", {31'b0, aes_mixed}, (f != 0 && f != 7) ? 1 : 0);
      rd(4'h0, v); chk("R9 field", v, RO | (f << 9));
    end
    // R8 bad sizes and misalignment
    do_reset();
    for (int s = 0; s < 4; s++) begin
      if (s != 2) begin
        wr(4'h0, 32'h0, s[1:0]);
        chk("R8 size ignored", ctrl_q, RST);
        rd(4'h0, v, s[1:0]); chk("R8 size read zero", v, 0);
      end
    end
    wr(4'h1, 32'h0); chk("R8 misaligned write", ctrl_q, RST);
    rd(4'h2, v); chk("R8 misaligned read", v, 0);
    wr(4'h9, 32'h1234); chk("R8 misaligned key", {31'b0, access_en}, 1);
    // R5 correct key
    wr(4'h0, 32'h0);
    wr(4'h4, 5'b01000);
    wr(4'h8, KEYV);
    chk("R5 key fields", ctrl_q, RO | 32'h0800_0E00);
    chk("R5 access", {31'b0, access_en}, 1);
    rd(4'h8, v); chk("R5 key reads zero", v, 0);
    // R6 wrong key
    wr(4'h8, KEYV ^ 32'h1);
    chk("R6 fields cleared", ctrl_q, RO);
    chk("R6 access dropped", {31'b0, access_en}, 0);
    // R7 closed block
    rd(4'h0, v); chk("R7 read zero", v, 0);
    wr(4'h0, 32'h0000_0055); chk("R7 ctrl write dropped", ctrl_q, RO);
    wr(4'h4, 32'h1F);
    wr(4'h8, KEYV);
    chk("R7 key still accepted", {31'b0, access_en}, 1);
    rd(4'h4, v); chk("R7 lock write dropped", v, 5'b01000);
    rd(4'h0, v); chk("R7 reopened ctrl", v, RO | 32'h0800_0E00);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule